// File: doc/BRIEF.md
# Wide-to-Narrow Alternating Data Port

This block lets an 8-bit host bus read a 16-bit disk data register through one I/O address. A single toggle flop chooses which half of the word each host read returns. When the toggle is clear, a host read fetches the whole 16-bit word from the device in one device read cycle. It returns the upper byte and keeps the lower byte in a holding register. The next host read returns the held byte without touching the device, and the toggle then points back at the upper half.

No host address line takes part in the byte choice. A reset clears the toggle, so software starts each transfer in a known position. When the bus address-enable input shows that a DMA cycle owns the bus, both device chip selects are forced inactive. A host read made in that state is ignored. Host writes to the port pass to the device as one write cycle, with the byte copied onto both halves of the device data bus. A second decoded register window passes through to the second device chip select.

All logic runs on one clock with a synchronous active-high reset. Host strobes are sampled as levels, and their edges are found inside the block.

Top module: `wide_narrow_port`

## Requirements
- R1: While reset is held and in the cycle after it, `host_rdata` equals all ones (0xFF), `dev_rd` and `dev_wr` are 0, `dev_cs` is 0, and the toggle points at the upper half.
- R2: A data-port read with the toggle at the upper half pulses `dev_rd` for exactly one clock, together with `dev_cs[0]`. Bits [15:8] of the word presented during that pulse appear on `host_rdata` one clock later.
- R3: A data-port read with the toggle at the lower half makes no device read. It returns bits [7:0] of the word fetched by the preceding upper-half read.
- R4: Upper and lower halves keep alternating across any number of reads, so a 512-byte sector arrives as 256 words in upper-then-lower order.
- R5: `host_rdata` does not change while a read strobe is held. The toggle flips only when a qualified read strobe ends.
- R6: Whenever `aen` is 1, both bits of `dev_cs` are 0 in that same cycle.
- R7: A read that starts while `aen` is 1 makes no device read, returns 0xFF, and leaves the toggle unchanged.
- R8: A reset between the two reads of a pair makes the next read an upper-half read with a fresh device fetch.
- R9: A data-port write pulses `dev_wr` for one clock with `dev_cs[0]` set. During that pulse `dev_wdata` carries the host byte in both halves. The write leaves the toggle unchanged.
- R10: `dev_cs[1]` follows `host_aux_cs` one clock later while `aen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the toggle |
| aen | input | 1 | Bus address enable, 1 while a DMA cycle owns the bus |
| host_cs | input | 1 | Decoded select of the data port |
| host_aux_cs | input | 1 | Decoded select of the second register window |
| host_rd | input | 1 | Host read strobe, active high level |
| host_wr | input | 1 | Host write strobe, active high level |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| dev_rdata | input | 16 | Device data word |
| dev_rd | output | 1 | Device read strobe, one clock per fetch |
| dev_wr | output | 1 | Device write strobe, one clock per write |
| dev_wdata | output | 16 | Device write word, host byte in both halves |
| dev_cs | output | 2 | Device chip selects, bit 0 data block, bit 1 second window |

## Verification
The bench builds the block with its defaults: an 8-bit host byte, a 16-bit device word and 0xFF as the idle read value. At these sizes a whole sector fits in a short run. The bench reads all 512 bytes from seeded random device words and checks every byte and the device fetch count of each read. Directed cases then place a DMA-time read, a write and a reset between the two halves of a pair. That is where a toggle that moves when it must not would show up.

// File: rtl/wnp_pkg.sv
package wnp_pkg;
  typedef enum logic {
    HALF_HI = 1'b0,
    HALF_LO = 1'b1
  } half_e;
endpackage

// File: rtl/wnp_strobe_qual.sv
module wnp_strobe_qual (
  input  logic clk,
  input  logic rst,
  input  logic aen,
  input  logic cs,
  input  logic rd,
  input  logic wr,
  output logic rd_go,
  output logic rd_blk,
  output logic rd_done,
  output logic wr_go
);
  logic rd_lvl, wr_lvl, rd_prev, wr_prev, rd_own;

  assign rd_lvl  = cs & rd;
  assign wr_lvl  = cs & wr;
  assign rd_go   = rd_lvl & ~rd_prev & ~aen;
  assign rd_blk  = rd_lvl & ~rd_prev & aen;
  assign rd_done = rd_own & ~rd_lvl;
  assign wr_go   = wr_lvl & ~wr_prev & ~aen;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
      rd_own  <= 1'b0;
    end else begin
      rd_prev <= rd_lvl;
      wr_prev <= wr_lvl;
      if (rd_go)        rd_own <= 1'b1;
      else if (rd_done) rd_own <= 1'b0;
    end
  end

  // R7: a read begun under DMA never becomes a qualified read
  assert_blk_not_owned_R7: assert property (@(posedge clk) disable iff (rst)
    rd_blk |=> !rd_done);
endmodule

// File: rtl/wnp_toggle.sv
module wnp_toggle
  import wnp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  output half_e half
);
  always_ff @(posedge clk) begin
    if (rst)      half <= HALF_HI;
    else if (adv) half <= (half == HALF_HI) ? HALF_LO : HALF_HI;
  end

  // R5 / R7: the toggle moves only on a qualified strobe end
  assert_half_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(half));
endmodule

// File: rtl/wnp_byte_path.sv
module wnp_byte_path
  import wnp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] IDLE_BYTE = '1,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic              rd_blk,
  input  half_e             half,
  input  logic [WORD_W-1:0] dev_rdata,
  output logic              fetch,
  output logic [DATA_W-1:0] host_rdata
);
  logic [DATA_W-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch      <= 1'b0;
      lo_hold    <= '0;
      host_rdata <= IDLE_BYTE;
    end else begin
      fetch <= rd_go && (half == HALF_HI);
      if (fetch) begin
        host_rdata <= dev_rdata[WORD_W-1 -: DATA_W];
        lo_hold    <= dev_rdata[DATA_W-1:0];
      end else if (rd_go && half == HALF_LO) begin
        host_rdata <= lo_hold;
      end else if (rd_blk) begin
        host_rdata <= IDLE_BYTE;
      end
    end
  end

  // R2: one device read clock per fetch
  assert_fetch_single_R2: assert property (@(posedge clk) disable iff (rst)
    fetch |=> !fetch);
  // R3: a lower-half read never fetches
  assert_lo_no_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_go && half == HALF_LO) |=> !fetch);
  // R5: output only moves on a start or a fetch
  assert_rdata_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !(rd_go || rd_blk || fetch) |=> $stable(host_rdata));
endmodule

// File: rtl/wnp_cs_gate.sv
module wnp_cs_gate (
  input  logic       clk,
  input  logic       rst,
  input  logic       aen,
  input  logic       blk0_req,
  input  logic       aux_cs,
  output logic [1:0] dev_cs
);
  logic aux_q;

  always_ff @(posedge clk) begin
    if (rst) aux_q <= 1'b0;
    else     aux_q <= aux_cs;
  end

  assign dev_cs = {aux_q, blk0_req} & {2{~aen}};

  // R6: both selects quiet during DMA
  assert_cs_quiet_dma_R6: assert property (@(posedge clk) disable iff (rst)
    aen |-> (dev_cs == 2'b00));
endmodule

// File: rtl/wide_narrow_port.sv
module wide_narrow_port
  import wnp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] IDLE_BYTE = '1,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aen,
  input  logic              host_cs,
  input  logic              host_aux_cs,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [WORD_W-1:0] dev_rdata,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [WORD_W-1:0] dev_wdata,
  output logic [1:0]        dev_cs
);
  logic  rd_go, rd_blk, rd_done, wr_go, fetch;
  half_e half;

  wnp_strobe_qual u_qual (
    .clk(clk), .rst(rst), .aen(aen), .cs(host_cs), .rd(host_rd), .wr(host_wr),
    .rd_go(rd_go), .rd_blk(rd_blk), .rd_done(rd_done), .wr_go(wr_go)
  );

  wnp_toggle u_tog (.clk(clk), .rst(rst), .adv(rd_done), .half(half));

  wnp_byte_path #(.DATA_W(DATA_W), .IDLE_BYTE(IDLE_BYTE)) u_path (
    .clk(clk), .rst(rst), .rd_go(rd_go), .rd_blk(rd_blk), .half(half),
    .dev_rdata(dev_rdata), .fetch(fetch), .host_rdata(host_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_wr    <= 1'b0;
      dev_wdata <= '0;
    end else begin
      dev_wr <= wr_go;
      if (wr_go) dev_wdata <= {host_wdata, host_wdata};
    end
  end

  assign dev_rd = fetch;

  wnp_cs_gate u_cs (
    .clk(clk), .rst(rst), .aen(aen), .blk0_req(fetch | dev_wr),
    .aux_cs(host_aux_cs), .dev_cs(dev_cs)
  );

  // R9: mirrored write word while the write strobe is out
  assert_wr_mirror_R9: assert property (@(posedge clk) disable iff (rst)
    dev_wr |-> (dev_wdata[WORD_W-1 -: DATA_W] == dev_wdata[DATA_W-1:0]));
  // R2 / R9: device strobes never overlap
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(dev_rd && dev_wr));
endmodule

// File: tb/wide_narrow_port_tb_top.sv
module wide_narrow_port_tb_top;
  logic clk = 1'b0;
  logic rst, aen, host_cs, host_aux_cs, host_rd, host_wr;
  logic [7:0]  host_wdata, host_rdata;
  logic [15:0] dev_rdata, dev_wdata;
  logic dev_rd, dev_wr;
  logic [1:0] dev_cs;

  int errors = 0, checks = 0;
  int devrd_cnt = 0;
  logic [15:0] mem [0:1023];
  int exp_word = 0;
  bit exp_lo = 1'b0;

  always #5 clk = ~clk;

  wide_narrow_port dut_i (
    .clk(clk), .rst(rst), .aen(aen), .host_cs(host_cs), .host_aux_cs(host_aux_cs),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dev_rdata(dev_rdata), .dev_rd(dev_rd),
    .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_cs(dev_cs)
  );

  always @(posedge clk) if (dev_rd) devrd_cnt <= devrd_cnt + 1;
  assign dev_rdata = mem[devrd_cnt[9:0]];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] d1, output logic [7:0] d2, output int pulses);
    int c0;
    c0 = devrd_cnt;
    @(negedge clk); host_cs = 1; host_rd = 1;
    repeat (3) @(negedge clk);
    d1 = host_rdata;
    repeat (2) @(negedge clk);
    d2 = host_rdata;
    host_cs = 0; host_rd = 0;
    repeat (2) @(negedge clk);
    pulses = devrd_cnt - c0;
  endtask

  // expected byte of the next normal read, advancing the model
  task automatic read_expect(input string tag);
    logic [7:0] d1, d2, e;
    int p;
    do_read(d1, d2, p);
    e = exp_lo ? mem[exp_word][7:0] : mem[exp_word][15:8];
    check(d1 == e, {tag, " data"}, d1, e);
    check(d1 == d2, "R5 stable during strobe", d2, d1);
    check(p == (exp_lo ? 0 : 1), {tag, " device reads"}, p, exp_lo ? 0 : 1);
    if (exp_lo) exp_word++;
    exp_lo = ~exp_lo;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    check(host_rdata == 8'hFF && dev_cs == 2'b00 && !dev_rd && !dev_wr,
          "R1 reset state", {dev_cs, host_rdata}, 8'hFF);
    rst = 0;
    @(negedge clk);
    check(host_rdata == 8'hFF && dev_cs == 2'b00, "R1 after reset", host_rdata, 8'hFF);
    if (exp_lo) begin exp_word++; exp_lo = 1'b0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] d1, d2;
    int p;
    void'($urandom(32'h5EC70A11));
    for (int i = 0; i < 1024; i++) mem[i] = 16'($urandom);
    rst = 1; aen = 0; host_cs = 0; host_aux_cs = 0; host_rd = 0; host_wr = 0;
    host_wdata = 0;
    repeat (3) @(negedge clk);
    do_reset();

    // R2 R3 R4: one whole sector, upper then lower per word
    for (int i = 0; i < 512; i++) read_expect(exp_lo ? "R3 R4 low" : "R2 R4 high");

    // R7: DMA-time read between halves
    read_expect("R2 high before dma");
    @(negedge clk); aen = 1; host_aux_cs = 1;
    @(negedge clk);
    check(dev_cs == 2'b00, "R6 selects quiet under aen", dev_cs, 0);
    do_read(d1, d2, p);
    check(d1 == 8'hFF, "R7 dma read value", d1, 8'hFF);
    check(p == 0, "R7 dma read no fetch", p, 0);
    check(dev_cs == 2'b00, "R6 selects quiet after dma read", dev_cs, 0);
    aen = 0;
    @(negedge clk);
    @(negedge clk);
    check(dev_cs == 2'b10, "R10 aux select passes", dev_cs, 2);
    host_aux_cs = 0;
    @(negedge clk);
    @(negedge clk);
    check(dev_cs == 2'b00, "R10 aux select drops", dev_cs, 0);
    read_expect("R7 toggle kept low");

    // R9: write between halves
    read_expect("R2 high before write");
    @(negedge clk); host_cs = 1; host_wr = 1; host_wdata = 8'hA5;
    @(negedge clk);
    check(dev_wr == 1'b1 && dev_cs == 2'b01, "R9 write strobe", {dev_cs, dev_wr}, 3);
    check(dev_wdata == 16'hA5A5, "R9 mirrored word", dev_wdata, 16'hA5A5);
    @(negedge clk);
    check(dev_wr == 1'b0, "R9 single write pulse", dev_wr, 0);
    host_cs = 0; host_wr = 0;
    repeat (2) @(negedge clk);
    read_expect("R9 toggle kept after write");

    // R8: reset mid-pair
    read_expect("R2 high before reset");
    do_reset();
    read_expect("R8 fresh high after reset");
    read_expect("R3 low after reset pair");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule